// File: doc/BRIEF.md
# Lane-Masked Vector Operand Port

This block sits between a SIMD execution datapath and a banked vector register file that it does not contain. On the read side it takes an operand selector and builds one 64-bit value per lane. A selector that names a vector register is turned into a register index by adding a per-wavefront base. The port then fetches that register and the one after it from the register file. For 64-bit operands the two are joined low/high. A selector that does not name a vector register makes every lane receive the same value from the scalar operand path. The value is then trimmed to the operand size. For floating-point sources, absolute-value and negate modifiers are applied to the sign bit.

On the write side the port turns a per-lane result vector into per-lane write enables and data for the register file. A lane is written only when its execution-mask bit is set, or when the mask override is raised. Results of load-type instructions use the mask captured when the instruction issued, in place of the live wavefront mask. A 64-bit result is split so that its low half goes to register N and its high half to register N+1.

Top module: `vop_port`

## Requirements
- R1: A read request sampled on a clock edge raises `rd_out_valid` for exactly the following cycle, with the result in `rd_out_data`. When no request is sampled, `rd_out_valid` is low and `rd_out_data` keeps its previous value.
- R2: When `rd_sel[SEL_W-1]` is 1, the selector names vector register N = `vreg_base` + `rd_sel[SEL_W-2:0]`. The port drives N on `rf_rd_idx_lo` and N+1 on `rf_rd_idx_hi`. A 64-bit lane value is {register N+1, register N}.
- R3: When `rd_sel[SEL_W-1]` is 0, every lane of the result is formed from `scalar_val` and not from the register file.
- R4: `rd_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Every lane bit above the operand width reads as 0.
- R5: With `rd_fp` set and a 32-bit or 64-bit size, `rd_abs` clears the sign bit and `rd_neg` inverts it. The sign bit is bit 31 or bit 63. With both set, abs is applied before neg, so the sign reads as 1. With `rd_fp` clear, or an 8-bit or 16-bit size, the modifiers have no effect.
- R6: A write changes lane l of a register only when the selected mask bit l is 1 or `wr_ignore_mask` is 1. All other lanes keep their contents.
- R7: With `wr_is_load` set, the selected mask is `inst_mask`. Otherwise it is `exec_mask`.
- R8: A write with `wr_wide` set puts lane bits 31:0 into register N and bits 63:32 into register N+1. A narrow write leaves register N+1 unchanged.
- R9: The write target is N = `vreg_base` + `wr_reg`, and the write takes effect on the clock edge that samples `wr_valid`. With `wr_valid` low, no lane enable is raised.
- R10: While `rst_n` is low, `rd_out_valid` and `rd_out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vreg_base | input | RF_AW | Per-wavefront base added to register offsets |
| rd_valid | input | 1 | Read request |
| rd_sel | input | SEL_W | Operand selector; top bit 1 means vector register |
| rd_size | input | 2 | Operand size code |
| rd_fp | input | 1 | Operand is floating point |
| rd_abs | input | 1 | Absolute-value modifier |
| rd_neg | input | 1 | Negate modifier |
| scalar_val | input | 64 | Value broadcast for non-vector selectors |
| rf_rd_idx_lo | output | RF_AW | Register file read index, low dword |
| rf_rd_idx_hi | output | RF_AW | Register file read index, high dword |
| rf_rd_data_lo | input | LANES*32 | Register file data for the low index, same cycle |
| rf_rd_data_hi | input | LANES*32 | Register file data for the high index, same cycle |
| rd_out_valid | output | 1 | Result valid |
| rd_out_data | output | LANES*64 | Per-lane 64-bit operand values |
| wr_valid | input | 1 | Write strobe |
| wr_reg | input | RF_AW | Destination register offset |
| wr_wide | input | 1 | Result is 64-bit |
| wr_is_load | input | 1 | Result comes from a load |
| wr_ignore_mask | input | 1 | Write every lane regardless of mask |
| exec_mask | input | LANES | Current wavefront execution mask |
| inst_mask | input | LANES | Mask captured when the instruction issued |
| wr_data | input | LANES*64 | Per-lane result values |
| rf_wr_idx_lo | output | RF_AW | Write index, low dword |
| rf_wr_idx_hi | output | RF_AW | Write index, high dword |
| rf_wr_en_lo | output | LANES | Per-lane write enable, low dword |
| rf_wr_en_hi | output | LANES | Per-lane write enable, high dword |
| rf_wr_data_lo | output | LANES*32 | Write data, low dword |
| rf_wr_data_hi | output | LANES*32 | Write data, high dword |

## Verification
A read result is due one cycle after the edge that samples the request. The write enables, indices and data are combinational and are due in the same cycle as the strobe. Write contents become visible through a read issued on any later cycle. The bench drives inputs just after a rising edge. On every falling edge it compares the outputs against a behavioural model: the read output registered at the previous edge, and the write controls derived from the inputs currently applied. It then advances the model by the request that the next edge will sample. A read and a write in the same cycle therefore expect the pre-write contents. Masked-off lanes are checked by reading back whole registers, after writes with random masks, after load-type writes and after writes with the override raised.

// File: rtl/vop_pkg.sv
`timescale 1ns/1ps
package vop_pkg;
  localparam int DW = 32;
  localparam int QW = 2 * DW;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } opsz_e;
endpackage

// File: rtl/vop_lane_fmt.sv
`timescale 1ns/1ps
// One lane of source formatting: select, join, trim, apply sign modifiers.
module vop_lane_fmt
  import vop_pkg::*;
(
  input  logic          is_vec,
  input  opsz_e         size,
  input  logic          fp,
  input  logic          abs_en,
  input  logic          neg_en,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [QW-1:0] scalar,
  output logic [QW-1:0] val
);
  logic [QW-1:0] raw;
  logic [QW-1:0] sized;

  always_comb begin
    raw = is_vec ? {hi, lo} : scalar;
    unique case (size)
      SZ_B8:   sized = {{(QW-8){1'b0}},  raw[7:0]};
      SZ_B16:  sized = {{(QW-16){1'b0}}, raw[15:0]};
      SZ_B32:  sized = {{DW{1'b0}},      raw[DW-1:0]};
      default: sized = raw;
    endcase
    val = sized;
    // Abs first, then neg: the order is fixed.
    if (fp && size == SZ_B32) begin
      if (abs_en) val[DW-1] = 1'b0;
      if (neg_en) val[DW-1] = ~val[DW-1];
    end
    if (fp && size == SZ_B64) begin
      if (abs_en) val[QW-1] = 1'b0;
      if (neg_en) val[QW-1] = ~val[QW-1];
    end
  end
endmodule

// File: rtl/vop_rd_stage.sv
`timescale 1ns/1ps
// Output register for the read path.
module vop_rd_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] din,
  output logic         valid_q,
  output logic [W-1:0] data_q
);
  logic         valid_d;
  logic [W-1:0] data_d;
  logic         data_ce;

  always_comb begin
    valid_d = req;
    data_ce = req;
    data_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (data_ce) data_q <= data_d;
    end
  end
endmodule

// File: rtl/vop_wr_gate.sv
`timescale 1ns/1ps
// Write side: lane mask selection, override and low/high split.
module vop_wr_gate
  import vop_pkg::*;
#(
  parameter int LANES = 64,
  parameter int RF_AW = 8
) (
  input  logic                vld,
  input  logic [RF_AW-1:0]    base,
  input  logic [RF_AW-1:0]    ofs,
  input  logic                wide,
  input  logic                is_load,
  input  logic                ignore_mask,
  input  logic [LANES-1:0]    exec_mask,
  input  logic [LANES-1:0]    inst_mask,
  input  logic [LANES*QW-1:0] data,
  output logic [RF_AW-1:0]    idx_lo,
  output logic [RF_AW-1:0]    idx_hi,
  output logic [LANES-1:0]    en_lo,
  output logic [LANES-1:0]    en_hi,
  output logic [LANES*DW-1:0] data_lo,
  output logic [LANES*DW-1:0] data_hi
);
  logic [LANES-1:0] lane_mask;

  always_comb begin
    lane_mask = is_load ? inst_mask : exec_mask;
    en_lo     = {LANES{vld}} & (lane_mask | {LANES{ignore_mask}});
    en_hi     = en_lo & {LANES{wide}};
    idx_lo    = base + ofs;
    idx_hi    = idx_lo + RF_AW'(1);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign data_lo[l*DW +: DW] = data[l*QW +: DW];
    assign data_hi[l*DW +: DW] = data[l*QW + DW +: DW];
  end
endmodule

// File: rtl/vop_port.sv
`timescale 1ns/1ps
// Lane-masked vector operand port: source gather/format and masked commit.
module vop_port
  import vop_pkg::*;
#(
  parameter int LANES = 64,
  parameter int SEL_W = 9,
  parameter int RF_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RF_AW-1:0]    vreg_base,
  input  logic                rd_valid,
  input  logic [SEL_W-1:0]    rd_sel,
  input  logic [1:0]          rd_size,
  input  logic                rd_fp,
  input  logic                rd_abs,
  input  logic                rd_neg,
  input  logic [63:0]         scalar_val,
  output logic [RF_AW-1:0]    rf_rd_idx_lo,
  output logic [RF_AW-1:0]    rf_rd_idx_hi,
  input  logic [LANES*32-1:0] rf_rd_data_lo,
  input  logic [LANES*32-1:0] rf_rd_data_hi,
  output logic                rd_out_valid,
  output logic [LANES*64-1:0] rd_out_data,
  input  logic                wr_valid,
  input  logic [RF_AW-1:0]    wr_reg,
  input  logic                wr_wide,
  input  logic                wr_is_load,
  input  logic                wr_ignore_mask,
  input  logic [LANES-1:0]    exec_mask,
  input  logic [LANES-1:0]    inst_mask,
  input  logic [LANES*64-1:0] wr_data,
  output logic [RF_AW-1:0]    rf_wr_idx_lo,
  output logic [RF_AW-1:0]    rf_wr_idx_hi,
  output logic [LANES-1:0]    rf_wr_en_lo,
  output logic [LANES-1:0]    rf_wr_en_hi,
  output logic [LANES*32-1:0] rf_wr_data_lo,
  output logic [LANES*32-1:0] rf_wr_data_hi
);
  localparam int OFS_W = SEL_W - 1;

  logic                sel_is_vec;
  logic [RF_AW-1:0]    sel_ofs;
  opsz_e               size_e;
  logic [LANES*QW-1:0] fmt_data;

  always_comb begin
    sel_is_vec   = rd_sel[SEL_W-1];
    sel_ofs      = RF_AW'(rd_sel[OFS_W-1:0]);
    size_e       = opsz_e'(rd_size);
    rf_rd_idx_lo = vreg_base + sel_ofs;
    rf_rd_idx_hi = rf_rd_idx_lo + RF_AW'(1);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vop_lane_fmt u_fmt (
      .is_vec (sel_is_vec),
      .size   (size_e),
      .fp     (rd_fp),
      .abs_en (rd_abs),
      .neg_en (rd_neg),
      .lo     (rf_rd_data_lo[l*DW +: DW]),
      .hi     (rf_rd_data_hi[l*DW +: DW]),
      .scalar (scalar_val),
      .val    (fmt_data[l*QW +: QW])
    );
  end

  vop_rd_stage #(.W(LANES*QW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (rd_valid),
    .din     (fmt_data),
    .valid_q (rd_out_valid),
    .data_q  (rd_out_data)
  );

  vop_wr_gate #(.LANES(LANES), .RF_AW(RF_AW)) u_wr (
    .vld         (wr_valid),
    .base        (vreg_base),
    .ofs         (wr_reg),
    .wide        (wr_wide),
    .is_load     (wr_is_load),
    .ignore_mask (wr_ignore_mask),
    .exec_mask   (exec_mask),
    .inst_mask   (inst_mask),
    .data        (wr_data),
    .idx_lo      (rf_wr_idx_lo),
    .idx_hi      (rf_wr_idx_hi),
    .en_lo       (rf_wr_en_lo),
    .en_hi       (rf_wr_en_hi),
    .data_lo     (rf_wr_data_lo),
    .data_hi     (rf_wr_data_hi)
  );
endmodule

// File: rtl/vop_port_chk.sv
`timescale 1ns/1ps
module vop_port_chk #(
  parameter int LANES = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_valid,
  input logic                rd_out_valid,
  input logic [LANES*64-1:0] rd_out_data,
  input logic                wr_valid,
  input logic                wr_wide,
  input logic                wr_is_load,
  input logic                wr_ignore_mask,
  input logic [LANES-1:0]    exec_mask,
  input logic [LANES-1:0]    inst_mask,
  input logic [LANES-1:0]    rf_wr_en_lo,
  input logic [LANES-1:0]    rf_wr_en_hi
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_out_valid);
  a_r1_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(rd_out_data));
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (rf_wr_en_lo == '0 && rf_wr_en_hi == '0));
  a_r6_override_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ignore_mask) |-> (&rf_wr_en_lo));
  a_r6_exec_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ignore_mask && !wr_is_load) |-> ((rf_wr_en_lo & ~exec_mask) == '0));
  a_r7_load_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ignore_mask && wr_is_load) |-> ((rf_wr_en_lo & ~inst_mask) == '0));
  a_r8_hi_within_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en_hi & ~rf_wr_en_lo) == '0);
  a_r8_narrow_no_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wide |-> (rf_wr_en_hi == '0));
endmodule

bind vop_port vop_port_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_vop_port.sv
`timescale 1ns/1ps
module sim_vop_port;
  localparam int LANES = 64;
  localparam int SEL_W = 9;
  localparam int RF_AW = 8;
  localparam int NREG  = 16;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [RF_AW-1:0]    vreg_base;
  logic                rd_valid;
  logic [SEL_W-1:0]    rd_sel;
  logic [1:0]          rd_size;
  logic                rd_fp, rd_abs, rd_neg;
  logic [63:0]         scalar_val;
  logic [RF_AW-1:0]    rf_rd_idx_lo, rf_rd_idx_hi;
  logic [LANES*32-1:0] rf_rd_data_lo, rf_rd_data_hi;
  logic                rd_out_valid;
  logic [LANES*64-1:0] rd_out_data;
  logic                wr_valid;
  logic [RF_AW-1:0]    wr_reg;
  logic                wr_wide, wr_is_load, wr_ignore_mask;
  logic [LANES-1:0]    exec_mask, inst_mask;
  logic [LANES*64-1:0] wr_data;
  logic [RF_AW-1:0]    rf_wr_idx_lo, rf_wr_idx_hi;
  logic [LANES-1:0]    rf_wr_en_lo, rf_wr_en_hi;
  logic [LANES*32-1:0] rf_wr_data_lo, rf_wr_data_hi;

  always #2 clk = ~clk;

  vop_port #(.LANES(LANES), .SEL_W(SEL_W), .RF_AW(RF_AW)) u0 (.*);

  // Register file storage outside the block.
  logic [31:0] rf [NREG][LANES];

  function automatic logic [31:0] init_word(int r, int l);
    return 32'hA500_0000 | (r << 16) | (l * 37);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int l = 0; l < LANES; l++) rf[r][l] <= init_word(r, l);
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (rf_wr_en_lo[l]) rf[rf_wr_idx_lo[3:0]][l] <= rf_wr_data_lo[l*32 +: 32];
        if (rf_wr_en_hi[l]) rf[rf_wr_idx_hi[3:0]][l] <= rf_wr_data_hi[l*32 +: 32];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rf_rd_data_lo[l*32 +: 32] = rf[rf_rd_idx_lo[3:0]][l];
      rf_rd_data_hi[l*32 +: 32] = rf[rf_rd_idx_hi[3:0]][l];
    end
  end

  // Behavioural reference model.
  logic [31:0]         exp_rf [NREG][LANES];
  logic                exp_valid;
  logic [LANES*64-1:0] exp_data;
  string               cur_tag, exp_tag;
  int                  checks = 0;
  int                  fails  = 0;
  bit                  done   = 0;

  function automatic logic [63:0] ref_fmt(logic vec, logic [1:0] sz, logic fp,
                                          logic ab, logic ng, logic [31:0] lo,
                                          logic [31:0] hi, logic [63:0] sc);
    logic [63:0] v;
    int w;
    v = vec ? {hi, lo} : sc;
    w = 8 << sz;
    if (w < 64) v = v & ((64'd1 << w) - 64'd1);
    if (fp && w >= 32) begin
      if (ab) v[w-1] = 1'b0;
      if (ng) v[w-1] = ~v[w-1];
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_valid = 1'b0;
      exp_data  = '0;
      exp_tag   = "R10";
      for (int r = 0; r < NREG; r++)
        for (int l = 0; l < LANES; l++) exp_rf[r][l] = init_word(r, l);
      checks++;
      if (rd_out_valid !== 1'b0 || rd_out_data !== '0) begin
        fails++;
        $display("FAIL R10: reset valid=%b data_nonzero=%b exp valid=0 data=0",
                 rd_out_valid, |rd_out_data);
      end
    end else if (!done) begin
      logic [LANES-1:0] em, eh;
      logic [RF_AW-1:0] widx, ridx;
      // Read output registered at the previous edge.
      checks++;
      if (rd_out_valid !== exp_valid) begin
        fails++;
        $display("FAIL %s: rd_out_valid act=%b exp=%b", exp_tag, rd_out_valid, exp_valid);
      end
      checks++;
      if (rd_out_data !== exp_data) begin
        fails++;
        for (int l = 0; l < LANES; l++)
          if (rd_out_data[l*64 +: 64] !== exp_data[l*64 +: 64]) begin
            $display("FAIL %s: lane %0d act=%h exp=%h", exp_tag, l,
                     rd_out_data[l*64 +: 64], exp_data[l*64 +: 64]);
            break;
          end
      end
      // Write controls for the inputs applied now.
      em = !wr_valid ? '0 : wr_ignore_mask ? '1 : wr_is_load ? inst_mask : exec_mask;
      eh = wr_wide ? em : '0;
      widx = vreg_base + wr_reg;
      checks++;
      if (rf_wr_en_lo !== em || rf_wr_en_hi !== eh) begin
        fails++;
        $display("FAIL %s: en_lo act=%h exp=%h en_hi act=%h exp=%h", cur_tag,
                 rf_wr_en_lo, em, rf_wr_en_hi, eh);
      end
      if (wr_valid) begin
        checks++;
        if (rf_wr_idx_lo !== widx || rf_wr_idx_hi !== widx + 1'b1) begin
          fails++;
          $display("FAIL R9: idx lo/hi act=%0d/%0d exp=%0d/%0d", rf_wr_idx_lo,
                   rf_wr_idx_hi, widx, widx + 1'b1);
        end
      end
      // Predict the read sampled at the next edge (pre-write contents).
      exp_tag = cur_tag;
      exp_valid = rd_valid;
      if (rd_valid) begin
        ridx = vreg_base + RF_AW'(rd_sel[SEL_W-2:0]);
        for (int l = 0; l < LANES; l++)
          exp_data[l*64 +: 64] = ref_fmt(rd_sel[SEL_W-1], rd_size, rd_fp, rd_abs, rd_neg,
                                         exp_rf[ridx[3:0]][l], exp_rf[4'(ridx[3:0] + 4'd1)][l],
                                         scalar_val);
      end
      // Apply the write committed at the next edge.
      for (int l = 0; l < LANES; l++) begin
        if (em[l]) exp_rf[widx[3:0]][l] = wr_data[l*64 +: 32];
        if (eh[l]) exp_rf[4'(widx[3:0] + 4'd1)][l] = wr_data[l*64 + 32 +: 32];
      end
    end
  end

  task automatic step(input logic rv, input logic vec, input int rofs, input logic [1:0] sz,
                      input logic fp, input logic ab, input logic ng, input logic [63:0] sc,
                      input logic wv, input int wofs, input logic wide, input logic ld,
                      input logic ign, input logic [LANES-1:0] em, input logic [LANES-1:0] im,
                      input string tag);
    @(posedge clk);
    #1;
    cur_tag        = tag;
    rd_valid       = rv;
    rd_sel         = {vec, 8'(rofs)};
    rd_size        = sz;
    rd_fp          = fp;
    rd_abs         = ab;
    rd_neg         = ng;
    scalar_val     = sc;
    wr_valid       = wv;
    wr_reg         = RF_AW'(wofs);
    wr_wide        = wide;
    wr_is_load     = ld;
    wr_ignore_mask = ign;
    exec_mask      = em;
    inst_mask      = im;
    for (int l = 0; l < LANES; l++) wr_data[l*64 +: 64] = {$urandom, $urandom};
  endtask

  task automatic rd(input logic vec, input int ofs, input logic [1:0] sz, input logic fp,
                    input logic ab, input logic ng, input logic [63:0] sc, input string tag);
    step(1'b1, vec, ofs, sz, fp, ab, ng, sc, 1'b0, 0, 1'b0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic wr(input int ofs, input logic wide, input logic ld, input logic ign,
                    input logic [LANES-1:0] em, input logic [LANES-1:0] im, input string tag);
    step(1'b0, 1'b0, 0, 2'd2, 1'b0, 1'b0, 1'b0, '0, 1'b1, ofs, wide, ld, ign, em, im, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 0, 2'd2, 1'b0, 1'b0, 1'b0, '0, 1'b0, 0, 1'b0, 1'b0, 1'b0,
         '1, '1, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      $display("FAIL watchdog: act=expired exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails + 1);
      $finish;
    end
  end

  initial begin
    logic [LANES-1:0] m1, m2;
    rst_n = 1'b0; vreg_base = RF_AW'(2); cur_tag = "R10";
    rd_valid = 0; rd_sel = '0; rd_size = 2'd2; rd_fp = 0; rd_abs = 0; rd_neg = 0;
    scalar_val = '0; wr_valid = 0; wr_reg = '0; wr_wide = 0; wr_is_load = 0;
    wr_ignore_mask = 0; exec_mask = '1; inst_mask = '1; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R10");
    // R2: narrow and wide vector reads
    rd(1'b1, 3, 2'd2, 0, 0, 0, '0, "R2");
    rd(1'b1, 4, 2'd3, 0, 0, 0, '0, "R2");
    // R1: idle cycles hold data, valid drops
    idle("R1"); idle("R1");
    // R3: scalar broadcast
    rd(1'b0, 5, 2'd3, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, "R3");
    // R4: sub-dword sizes
    rd(1'b1, 6, 2'd0, 0, 0, 0, '0, "R4");
    rd(1'b1, 6, 2'd1, 0, 0, 0, '0, "R4");
    rd(1'b0, 0, 2'd1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    // R5: modifiers
    rd(1'b1, 7, 2'd2, 1, 1, 0, '0, "R5");
    rd(1'b1, 7, 2'd2, 1, 0, 1, '0, "R5");
    rd(1'b1, 7, 2'd2, 1, 1, 1, '0, "R5");
    rd(1'b1, 7, 2'd3, 1, 1, 1, '0, "R5");
    rd(1'b0, 0, 2'd3, 1, 0, 1, 64'h3FF0_0000_0000_0000, "R5");
    rd(1'b1, 7, 2'd2, 0, 1, 1, '0, "R5");
    rd(1'b0, 0, 2'd1, 1, 1, 1, 64'h0000_0000_0000_BC00, "R5");
    // R6: random exec mask, narrow; then read back N and N+1
    m1 = {$urandom, $urandom};
    wr(1, 1'b0, 0, 0, m1, ~m1, "R6");
    rd(1'b1, 1, 2'd3, 0, 0, 0, '0, "R6");
    wr(2, 1'b0, 0, 1, '0, '0, "R6");
    rd(1'b1, 2, 2'd2, 0, 0, 0, '0, "R6");
    // R7: load uses the issue-time mask
    m1 = {$urandom, $urandom}; m2 = {$urandom, $urandom};
    wr(4, 1'b0, 1, 0, m1, m2, "R7");
    rd(1'b1, 4, 2'd2, 0, 0, 0, '0, "R7");
    // R8: wide split, masked
    wr(8, 1'b1, 0, 0, m2, m1, "R8");
    rd(1'b1, 8, 2'd3, 0, 0, 0, '0, "R8");
    rd(1'b1, 9, 2'd2, 0, 0, 0, '0, "R8");
    // R9: strobe low with data present changes nothing
    step(1'b0, 1'b0, 0, 2'd2, 0, 0, 0, '0, 1'b0, 10, 1'b1, 0, 1, '1, '1, "R9");
    rd(1'b1, 10, 2'd3, 0, 0, 0, '0, "R9");
    // Same-cycle read and write: read sees old contents
    step(1'b1, 1'b1, 11, 2'd3, 0, 0, 0, '0, 1'b1, 11, 1'b1, 0, 1, '0, '0, "R9");
    rd(1'b1, 11, 2'd3, 0, 0, 0, '0, "R8");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom % 4;
      step(k != 1, 1'($urandom), $urandom % 13, 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), {$urandom, $urandom}, k != 0, $urandom % 13, 1'($urandom),
           1'($urandom), ($urandom % 5) == 0, {$urandom, $urandom}, {$urandom, $urandom},
           "R6");
    end
    // Read back every register whole
    for (int r = 0; r < 13; r++) rd(1'b1, r, 2'd3, 0, 0, 0, '0, "R6");
    idle("R1"); idle("R1");
    @(posedge clk);
    #1 done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule